// File: doc/BRIEF.md
# Framed link receiver with CRC check

This block sits behind a deserializer and 8b/10b decoder. Each clock it may receive one 16-bit word and a 2-bit flag that marks control characters. It keeps only plain data words. Every three of them become one 48-bit word, which it writes to a downstream FIFO with a one-cycle strobe. Frame words and data words are both written.

Frames close with two frame words. The block runs a CRC-16 over every plain data word from the start of the frame through the last word of the first frame word. It compares that value with the checksum carried in the low field of the second frame word. It then reports a one-cycle good or bad result, updates three frame counters, latches the computed CRC and the frame's data-word count, and sets a sticky error flag on a mismatch.

A small start-up machine keeps the block idle after reset until the first plain data word arrives while the link is locked. Loss of either lock indication returns it to idle, which throws away any partial word and any partial frame.

Top module: `link_frame_rx`

## Requirements
- R1: While `rst` is high (synchronous, active high) and in the cycle after it falls, `out_wr`, `res_valid`, `res_bad` and `err_flag` are 0, and all three counters, `crc_value` and `hit_count` are 0.
- R2: A word is accepted when `freq_lock` and `pll_lock` are both 1 and `rx_ctrl` is 2'b00. Three accepted words form one 48-bit word, with the first accepted word in bits 47..32 and the last in bits 15..0. `out_wr` is high for exactly the cycle after the third word's clock edge, with `out_word` holding the assembled value.
- R3: A word with any `rx_ctrl` bit set is skipped. It does not advance the assembly, does not enter the CRC, and causes no write. While idle after reset, such words leave the block idle.
- R4: If `freq_lock` or `pll_lock` is 0 at a clock edge, the block returns to idle. Any partly assembled word, the running CRC, the running data-word count and the frame-word phase are all discarded. The next accepted word starts a fresh 48-bit word and a fresh frame.
- R5: An assembled word is the first frame word when bit 47 is 1 and bits 43..32 equal 12'hA5A. A word with bit 47 set and any other value in bits 43..32 is treated as data.
- R6: The CRC uses polynomial 0x1021 and seed 0xFFFF, processes each 16-bit word most-significant bit first, and applies no final inversion. It covers every accepted word of the frame up to and including the last word of the first frame word.
- R7: The assembled word that follows the first frame word is the second frame word, whatever its contents. It is excluded from the CRC. Its bits 15..0 are compared with the computed CRC, and in the same cycle as its write `res_valid` is 1 for one cycle, with `res_bad` 0 on a match and 1 on a mismatch.
- R8: `cnt_total` increases by one with each result. `cnt_good` or `cnt_bad` increases according to `res_bad`. The counters are stable in every other cycle.
- R9: `err_flag` becomes 1 with the first mismatch and stays 1 until `rst`.
- R10: `crc_value` shows the CRC computed for the frame last reported, from the result cycle until the next result.
- R11: `hit_count` shows how many data words (assembled words other than frame words) the frame last reported contained, saturating at 2^HIT_W-1.
- R12: After the second frame word, the CRC is reseeded, so each frame's check is independent of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | 16 | Decoded word from the deserializer |
| rx_ctrl | input | 2 | Per-byte control-character flags |
| freq_lock | input | 1 | Receiver frequency lock |
| pll_lock | input | 1 | Receiver PLL lock |
| out_word | output | 48 | Assembled word for the FIFO |
| out_wr | output | 1 | One-cycle FIFO write strobe |
| hit_count | output | HIT_W | Data words in the last reported frame |
| crc_value | output | 16 | CRC computed for the last reported frame |
| res_valid | output | 1 | Frame result strobe |
| res_bad | output | 1 | Frame result was a CRC mismatch |
| cnt_total | output | CNT_W | Frames reported |
| cnt_good | output | CNT_W | Frames with matching CRC |
| cnt_bad | output | CNT_W | Frames with mismatching CRC |
| err_flag | output | 1 | Sticky CRC mismatch indication |

## Verification
The main collision is at the last word of the second frame word. In that one clock edge the block writes a 48-bit word to the FIFO, issues the result strobe, updates the counters, latches the CRC and the data-word count, reseeds the CRC and wraps the assembly phase. Every frame in the vector table provokes this, and the bench judges it in the single cycle after the edge by comparing `out_word`, `out_wr`, `res_valid`, `res_bad`, the counters, `crc_value` and `hit_count` against its own model. A second collision, loss of lock against a half-built word or against the frame-word phase, is forced by directed tests. The frame that follows must then assemble correctly and check good.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  localparam int          LANE_W   = 16;
  localparam int          TAG_W    = 12;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [11:0] FW0_TAG  = 12'hA5A;

  typedef enum logic {ST_WAIT, ST_RUN} lrx_state_t;

  // One 16-bit step of the CRC, most significant data bit first.
  function automatic logic [15:0] crc16_word(input logic [15:0] crc_in,
                                             input logic [15:0] data);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ data[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/lrx_assembler.sv
module lrx_assembler #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic [W-1:0]     din,
  output logic [W*N-1:0]   grp_word,
  output logic             grp_done,
  output logic [W*N-1:0]   out_word,
  output logic             out_wr
);
  localparam int OW = W * N;
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ph;
  logic [W-1:0]  hold [N-1];

  assign grp_done = take && (ph == PW'(N - 1));

  generate
    for (genvar k = 0; k < N - 1; k++) begin : g_slot
      assign grp_word[OW-1-k*W -: W] = hold[k];
      always_ff @(posedge clk) begin
        if (take && ph == PW'(k)) hold[k] <= din;
      end
    end
  endgenerate
  assign grp_word[W-1:0] = din;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph <= '0;
    end else if (take) begin
      ph <= grp_done ? '0 : ph + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr   <= 1'b0;
      out_word <= '0;
    end else begin
      out_wr <= grp_done;
      if (grp_done) out_word <= grp_word;
    end
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    ph < PW'(N));

endmodule

// File: rtl/lrx_crc16.sv
module lrx_crc16
  import lrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [15:0] din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (en)     crc <= crc16_word(crc, din);
  end

endmodule

// File: rtl/lrx_tally.sv
module lrx_tally #(
  parameter int CNT_W = 32,
  parameter int HIT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             bad,
  input  logic [15:0]      crc_in,
  input  logic [HIT_W-1:0] hits_in,
  output logic             res_valid,
  output logic             res_bad,
  output logic [15:0]      crc_out,
  output logic [HIT_W-1:0] hit_out,
  output logic [CNT_W-1:0] cnt_total,
  output logic [CNT_W-1:0] cnt_good,
  output logic [CNT_W-1:0] cnt_bad,
  output logic             err_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_bad   <= 1'b0;
      crc_out   <= '0;
      hit_out   <= '0;
      cnt_total <= '0;
      cnt_good  <= '0;
      cnt_bad   <= '0;
      err_flag  <= 1'b0;
    end else begin
      res_valid <= done;
      res_bad   <= done && bad;
      if (done) begin
        crc_out   <= crc_in;
        hit_out   <= hits_in;
        cnt_total <= cnt_total + CNT_W'(1);
        if (bad) begin
          cnt_bad  <= cnt_bad + CNT_W'(1);
          err_flag <= 1'b1;
        end else begin
          cnt_good <= cnt_good + CNT_W'(1);
        end
      end
    end
  end

  assert_bad_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    res_bad |-> res_valid);

  assert_total_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(cnt_total));

  assert_total_step_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> cnt_total == $past(cnt_total) + CNT_W'(1));

  assert_counts_sum_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_good + cnt_bad == cnt_total);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(err_flag) |-> err_flag);

  assert_crc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(crc_out));

endmodule

// File: rtl/link_frame_rx.sv
module link_frame_rx
  import lrx_pkg::*;
#(
  parameter int GROUP_WORDS = 3,
  parameter int CNT_W       = 32,
  parameter int HIT_W       = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [15:0]                     rx_word,
  input  logic [1:0]                      rx_ctrl,
  input  logic                            freq_lock,
  input  logic                            pll_lock,
  output logic [LANE_W*GROUP_WORDS-1:0]   out_word,
  output logic                            out_wr,
  output logic [HIT_W-1:0]                hit_count,
  output logic [15:0]                     crc_value,
  output logic                            res_valid,
  output logic                            res_bad,
  output logic [CNT_W-1:0]                cnt_total,
  output logic [CNT_W-1:0]                cnt_good,
  output logic [CNT_W-1:0]                cnt_bad,
  output logic                            err_flag
);
  localparam int OUT_W    = LANE_W * GROUP_WORDS;
  localparam int FLAG_BIT = OUT_W - 1;
  localparam int TAG_HI   = OUT_W - 5;

  // Named internal events
  logic              lock_ok, take, clr;
  logic              grp_done, is_fw0, eop, sop, is_data, frame_done, mismatch;
  logic [OUT_W-1:0]  grp_word;
  logic [15:0]       crc_now;
  lrx_state_t        state_q;
  logic              trail_q, fresh_q;
  logic [HIT_W-1:0]  hit_run;

  assign lock_ok    = freq_lock && pll_lock;
  assign take       = lock_ok && (rx_ctrl == 2'b00);
  assign clr        = !lock_ok;
  assign is_fw0     = grp_word[FLAG_BIT] && (grp_word[TAG_HI -: TAG_W] == FW0_TAG);
  assign eop        = grp_done && !trail_q && is_fw0;
  assign is_data    = grp_done && !trail_q && !is_fw0;
  assign frame_done = grp_done && trail_q;
  assign mismatch   = crc_now != grp_word[LANE_W-1:0];
  assign sop        = take && (state_q == ST_WAIT || fresh_q);

  lrx_assembler #(.W(LANE_W), .N(GROUP_WORDS)) asm_i (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .din(rx_word),
    .grp_word(grp_word), .grp_done(grp_done),
    .out_word(out_word), .out_wr(out_wr)
  );

  lrx_crc16 crc_i (
    .clk(clk), .rst(rst), .init(clr || frame_done),
    .en(take && !trail_q), .din(rx_word), .crc(crc_now)
  );

  lrx_tally #(.CNT_W(CNT_W), .HIT_W(HIT_W)) tally_i (
    .clk(clk), .rst(rst), .done(frame_done), .bad(mismatch),
    .crc_in(crc_now), .hits_in(hit_run),
    .res_valid(res_valid), .res_bad(res_bad), .crc_out(crc_value),
    .hit_out(hit_count), .cnt_total(cnt_total), .cnt_good(cnt_good),
    .cnt_bad(cnt_bad), .err_flag(err_flag)
  );

  // Start-up machine and frame-word phase
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= ST_WAIT;
      trail_q <= 1'b0;
      fresh_q <= 1'b0;
      hit_run <= '0;
    end else begin
      if (take) state_q <= ST_RUN;
      if (eop)             trail_q <= 1'b1;
      else if (frame_done) trail_q <= 1'b0;
      if (frame_done) fresh_q <= 1'b1;
      else if (take)  fresh_q <= 1'b0;
      if (frame_done)                   hit_run <= '0;
      else if (is_data && hit_run != '1) hit_run <= hit_run + HIT_W'(1);
    end
  end

  assert_ctrl_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_ctrl != 2'b00) |=> !out_wr);

  assert_lock_drop_R4: assert property (@(posedge clk) disable iff (rst)
    !lock_ok |=> (state_q == ST_WAIT && !out_wr));

  assert_result_with_write_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> out_wr);

  assert_result_after_fw0_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(trail_q));

  assert_fresh_seed_R12: assert property (@(posedge clk) disable iff (rst)
    sop |-> crc_now == CRC_SEED);

endmodule

// File: tb/link_frame_rx_tb_top.sv
module link_frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HIT_W      = 12;
  localparam int CNT_W      = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic [15:0]       rx_word;
  logic [1:0]        rx_ctrl;
  logic              freq_lock, pll_lock;
  logic [47:0]       out_word;
  logic              out_wr;
  logic [HIT_W-1:0]  hit_count;
  logic [15:0]       crc_value;
  logic              res_valid, res_bad;
  logic [CNT_W-1:0]  cnt_total, cnt_good, cnt_bad;
  logic              err_flag;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model state
  logic [15:0] b_crc = 16'hFFFF;
  int          b_hits = 0;
  int          b_total = 0, b_good = 0, b_badc = 0;
  logic        b_err = 1'b0;
  logic [15:0] b_last_crc = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_frame_rx #(.GROUP_WORDS(3), .CNT_W(CNT_W), .HIT_W(HIT_W)) dut_i (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rx_ctrl(rx_ctrl),
    .freq_lock(freq_lock), .pll_lock(pll_lock),
    .out_word(out_word), .out_wr(out_wr), .hit_count(hit_count),
    .crc_value(crc_value), .res_valid(res_valid), .res_bad(res_bad),
    .cnt_total(cnt_total), .cnt_good(cnt_good), .cnt_bad(cnt_bad),
    .err_flag(err_flag)
  );

  // Frame vectors: [15:12] data words, [11] corrupt checksum, [7:0] pattern seed
  localparam logic [15:0] VEC [0:5] = '{
    16'h2011, 16'h0022, 16'h5833, 16'h1044, 16'h3855, 16'h4066
  };

  // Reference CRC written as a register shifted left with the feedback taps applied
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    logic        top;
    r = c;
    for (int b = 0; b < 16; b++) begin
      top = r[15] ^ d[15-b];
      r   = r << 1;
      if (top) r = r ^ 16'b0001_0000_0010_0001;
    end
    return r;
  endfunction

  function automatic logic [47:0] mk(input logic [7:0] sd, input int i);
    logic [15:0] a, b, c;
    logic [7:0]  lo;
    lo = 8'(i);
    a  = {1'b0, sd[6:0], lo};
    b  = 16'(int'(sd) * 37 + i);
    c  = 16'(i * 4099) ^ {sd, sd};
    return {a, b, c};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put16(input logic [15:0] w, input logic [1:0] k);
    rx_word = w;
    rx_ctrl = k;
    @(posedge clk);
    #1;
  endtask

  task automatic put48(input logic [47:0] w, input bit in_crc);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] piece;
      piece = w[47-16*i -: 16];
      if (in_crc) b_crc = ref_crc(b_crc, piece);
      put16(piece, 2'b00);
    end
    chk("R2 write strobe", 64'(out_wr), 64'(1));
    chk("R2 assembled word", 64'(out_word), 64'(w));
  endtask

  task automatic put_data(input logic [47:0] w);
    put48(w, 1'b1);
    chk("R7 no result on data", 64'(res_valid), 64'(0));
    b_hits++;
  endtask

  task automatic frame_end(input bit corrupt, input string tag);
    logic [47:0] fw0, fw1;
    logic [15:0] exp_crc;
    fw0 = {1'b1, 3'b000, 12'hA5A, 16'h0000, 16'h1234};
    put48(fw0, 1'b1);
    exp_crc = b_crc;
    fw1 = {1'b1, 15'h0, 16'hBEEF, corrupt ? (exp_crc ^ 16'h0001) : exp_crc};
    put48(fw1, 1'b0);
    b_total++;
    if (corrupt) begin b_badc++; b_err = 1'b1; end
    else b_good++;
    b_last_crc = exp_crc;
    chk({tag, " R7 result valid"}, 64'(res_valid), 64'(1));
    chk({tag, " R7 result bad"}, 64'(res_bad), 64'(corrupt));
    chk({tag, " R6 R10 crc value"}, 64'(crc_value), 64'(exp_crc));
    chk({tag, " R11 hit count"}, 64'(hit_count), 64'((b_hits > 4095) ? 4095 : b_hits));
    chk({tag, " R8 total"}, 64'(cnt_total), 64'(b_total));
    chk({tag, " R8 good"}, 64'(cnt_good), 64'(b_good));
    chk({tag, " R8 bad"}, 64'(cnt_bad), 64'(b_badc));
    chk({tag, " R9 err flag"}, 64'(err_flag), 64'(b_err));
    b_crc  = 16'hFFFF;   // R12: reseeded after the second frame word
    b_hits = 0;
  endtask

  task automatic check_idle_state(input string tag);
    chk({tag, " R1 write"}, 64'(out_wr), 64'(0));
    chk({tag, " R1 valid"}, 64'(res_valid), 64'(0));
    chk({tag, " R1 total"}, 64'(cnt_total), 64'(0));
    chk({tag, " R1 good"}, 64'(cnt_good), 64'(0));
    chk({tag, " R1 bad"}, 64'(cnt_bad), 64'(0));
    chk({tag, " R1 R9 err"}, 64'(err_flag), 64'(0));
    chk({tag, " R1 crc"}, 64'(crc_value), 64'(0));
    chk({tag, " R1 hits"}, 64'(hit_count), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; freq_lock = 1'b1; pll_lock = 1'b1;
    rx_word = 16'h00BC; rx_ctrl = 2'b01;
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    check_idle_state("reset");

    // R3: control words while idle do nothing
    for (int i = 0; i < 4; i++) begin
      put16(16'h00BC, (i % 2 == 0) ? 2'b01 : 2'b11);
      chk("R3 idle control word", 64'(out_wr), 64'(0));
    end

    // Table of frames
    for (int v = 0; v < 6; v++) begin
      logic [15:0] e;
      e = VEC[v];
      for (int i = 0; i < int'(e[15:12]); i++) put_data(mk(e[7:0], i));
      frame_end(e[11], "table");
    end

    // R9: flag stays set across a good frame
    put_data(mk(8'h77, 1));
    frame_end(1'b0, "sticky");
    chk("R9 flag after good", 64'(err_flag), 64'(1));

    // R10: crc_value held while the next frame builds
    put_data(mk(8'h12, 3));
    put_data(mk(8'h12, 4));
    chk("R10 crc held", 64'(crc_value), 64'(b_last_crc));

    // R3: control word inside a group is skipped (not assembled, not in CRC)
    begin
      logic [47:0] w;
      w = mk(8'h2A, 9);
      put16(w[47:32], 2'b00);
      put16(16'h00BC, 2'b10);
      chk("R3 no write on control", 64'(out_wr), 64'(0));
      put16(w[31:16], 2'b00);
      put16(w[15:0], 2'b00);
      b_crc = ref_crc(ref_crc(ref_crc(b_crc, w[47:32]), w[31:16]), w[15:0]);
      b_hits++;
      chk("R3 word around control", 64'(out_word), 64'(w));
      frame_end(1'b0, "ctrl-mid");
    end

    // R4: lock loss in the middle of a group
    begin
      put16(16'hDEAD, 2'b00);
      freq_lock = 1'b0;
      put16(16'h5555, 2'b00);
      chk("R4 no write while unlocked", 64'(out_wr), 64'(0));
      freq_lock = 1'b1;
      b_crc = 16'hFFFF; b_hits = 0;
      put_data(mk(8'h31, 0));
      put_data(mk(8'h31, 1));
      frame_end(1'b0, "R4 relock");
    end

    // R4: lock loss between the two frame words
    begin
      put_data(mk(8'h41, 0));
      put48({1'b1, 3'b000, 12'hA5A, 32'h0}, 1'b1);
      pll_lock = 1'b0;
      put16(16'h0000, 2'b00);
      pll_lock = 1'b1;
      b_crc = 16'hFFFF; b_hits = 0;
      put_data(mk(8'h42, 0));
      frame_end(1'b0, "R4 trail drop");
    end

    // R5: bit 47 with a different tag is data
    put_data({1'b1, 3'b000, 12'hA5B, 32'h0000_1111});
    put_data(mk(8'h50, 2));
    frame_end(1'b0, "R5 fake tag");

    // R11: hit count saturates
    for (int i = 0; i < 4100; i++) begin
      logic [47:0] w;
      w = mk(8'h60, i);
      for (int p = 0; p < 3; p++) begin
        b_crc = ref_crc(b_crc, w[47-16*p -: 16]);
        put16(w[47-16*p -: 16], 2'b00);
      end
      b_hits++;
    end
    frame_end(1'b0, "R11 saturate");

    // R1 R9: reset clears counters and the sticky flag
    rst = 1'b1;
    rx_ctrl = 2'b01;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    b_total = 0; b_good = 0; b_badc = 0; b_err = 1'b0;
    b_crc = 16'hFFFF; b_hits = 0;
    check_idle_state("re-reset");

    // R12: a frame after reset checks independently
    put_data(mk(8'h70, 0));
    frame_end(1'b0, "R12 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule